// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the bit-level receiver of an I2C slave and decides, from the bytes received after each START, whether the slave is being addressed. It compares the address phase against two programmed own addresses. Each address can be in 7-bit or 10-bit form, or the pair can act as the inclusive bounds of an address range. It can also recognise the general call address and the SMBus alert response address, and it spots the high-speed master code. When an address hits, it emits a one-cycle match strobe with a match-type code and the direction bit. It then holds a transfer-active flag until the transfer is terminated.

The receiver supplies START (including repeated START) and STOP strobes, a strobe per received byte, a NACK strobe and a bit-error strobe. A bit error means the slave drove SDA but sampled another level. The high-speed flag tells the pin logic to bypass its glitch filters and output delay; it stays set until the next STOP.

The controller is a five-state machine. In IDLE it waits for START. In HEAD the first byte after a START is classified. In TENLO it waits for the low byte of a 10-bit address. XFER is the addressed transfer. In SKIP the slave is not addressed and waits for the next START or STOP. The named transitions are:
- start (any state to HEAD) and stop (any state to IDLE).
- hit (HEAD or TENLO to XFER) and tenhdr (HEAD to TENLO).
- miss (HEAD or TENLO to SKIP) and terminate (XFER to SKIP, on a NACK or a bit error).

Top module: `i2c_addr_match`

## Requirements
- R1: A 7-bit first byte whose upper seven bits equal `own_addr0` (with `own0_ten`=0, `range_mode`=0) gives, on the clock edge that takes the byte, `match_pulse`=1 for one cycle, `match_kind`=1, `rd_not_wr`=byte bit 0, and `xfer_active`=1.
- R2: A 7-bit match on `own_addr1` gives `match_kind`=2; when both addresses hold the same value, address 0 wins (kind 1).
- R3: With `range_mode`=1, any address with `own_addr0` <= address <= `own_addr1` (both bounds inclusive, width set by `own0_ten`) matches with `match_kind`=2; addresses outside miss.
- R4: A 10-bit address is a header byte 11110, a[9:8], R/W, followed by a byte holding a[7:0]; a full match gives the strobe on the edge that takes the second byte, with the kind of the address that hit.
- R5: After a 10-bit write match and before STOP, a repeated START followed by a header with R/W=1 and the same a[9:8] matches at once with the same kind and `rd_not_wr`=1; after a STOP that header alone does not match.
- R6: With `gcall_en`=1, the byte 0x00 gives `match_kind`=3 and `rd_not_wr`=0; with `gcall_en`=0 it does not hit through this path.
- R7: With `alert_en`=1, a first byte whose upper seven bits are 0001100 gives `match_kind`=4 with the R/W bit as sent; with `alert_en`=0 it does not match.
- R8: A first byte of the form 00001xxx sets `hs_active` without a match; the flag survives repeated STARTs and later matches and clears on the edge that takes STOP.
- R9: In a transfer, a NACK ends it (`xfer_active`=0 on the next edge) unless `nack_ignore`=1, in which case the transfer continues.
- R10: In a transfer, a bit error ends it on the next edge.
- R11: START or STOP ends a transfer on the next edge; after a START the next byte is decoded as a fresh address.
- R12: Bytes that arrive in IDLE, in SKIP, or that match no enabled address, give no strobe and leave `xfer_active`=0.
- R13: After reset all outputs are 0 and `match_kind` is 0 whenever `xfer_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | START or repeated START strobe |
| stop_det | input | 1 | STOP strobe |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte, MSB first on the wire |
| nack_det | input | 1 | NACK seen after a byte |
| bit_err | input | 1 | Driven SDA level differed from sampled level |
| own_addr0 | input | 10 | First own address / range low bound |
| own0_ten | input | 1 | Address 0 (and range) uses 10-bit form |
| own_addr1 | input | 10 | Second own address / range high bound |
| own1_ten | input | 1 | Address 1 uses 10-bit form |
| range_mode | input | 1 | Treat the two addresses as an inclusive range |
| gcall_en | input | 1 | Accept general call |
| alert_en | input | 1 | Accept SMBus alert response address |
| nack_ignore | input | 1 | A NACK does not end the transfer |
| match_pulse | output | 1 | One-cycle strobe on a hit |
| match_kind | output | 3 | 0 none, 1 addr0, 2 addr1/range, 3 general call, 4 alert |
| rd_not_wr | output | 1 | Direction of the matched transfer |
| hs_active | output | 1 | High-speed mode, filters bypassed |
| xfer_active | output | 1 | Addressed transfer in progress |

## Verification
Every output is a register updated on the edge that takes the causing strobe. So a match is due on the edge that takes the deciding byte: the first byte for 7-bit, general call, alert and the repeated 10-bit read, and the second byte for a full 10-bit address. The end of a transfer and the high-speed set and clear are due on the edge that takes the START, STOP, NACK, bit-error or master-code strobe. The bench drives each strobe for one cycle from the falling edge and samples at the following falling edge, half a cycle after the due edge. It looks one more cycle later to confirm the strobe has fallen while the transfer flag holds.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HEAD  = 3'd1,
        ST_TENLO = 3'd2,
        ST_XFER  = 3'd3,
        ST_SKIP  = 3'd4
    } st_e;

    typedef enum logic [2:0] {
        MK_NONE  = 3'd0,
        MK_ADDR0 = 3'd1,
        MK_ADDR1 = 3'd2,
        MK_GCALL = 3'd3,
        MK_ALERT = 3'd4
    } mk_e;

    localparam logic [4:0] TEN_HDR_PFX = 5'b11110;
    localparam logic [4:0] HS_CODE_PFX = 5'b00001;
    localparam logic [6:0] ALERT_ADDR  = 7'b0001100;

endpackage

// File: rtl/i2cam_hdr.sv
module i2cam_hdr #(
    parameter int BYTE_W = 8,
    parameter int SEVEN_W = 7
) (
    input  logic [BYTE_W-1:0]  hdr_byte,
    output logic               is_gcall,
    output logic               is_alert,
    output logic               is_hs,
    output logic               is_ten,
    output logic [SEVEN_W-1:0] addr7
);
    import i2cam_pkg::*;

    localparam int PFX_LSB = BYTE_W - 5;

    always_comb begin
        addr7    = hdr_byte[BYTE_W-1:1];
        is_gcall = (hdr_byte == '0);
        is_alert = (hdr_byte[BYTE_W-1:1] == ALERT_ADDR);
        is_hs    = (hdr_byte[BYTE_W-1:PFX_LSB] == HS_CODE_PFX);
        is_ten   = (hdr_byte[BYTE_W-1:PFX_LSB] == TEN_HDR_PFX);
    end

endmodule

// File: rtl/i2cam_cmp.sv
module i2cam_cmp #(
    parameter int ADDR_W = 10,
    parameter int SEVEN_W = 7
) (
    input  logic [ADDR_W-1:0] cand,
    input  logic              cand_ten,
    input  logic [ADDR_W-1:0] own_addr0,
    input  logic              own0_ten,
    input  logic [ADDR_W-1:0] own_addr1,
    input  logic              own1_ten,
    input  logic              range_mode,
    output logic              hit0,
    output logic              hit1
);
    localparam logic [ADDR_W-1:0] MASK7 = {{(ADDR_W-SEVEN_W){1'b0}}, {SEVEN_W{1'b1}}};

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] c_m, a0_m, a1_m;

    always_comb begin
        mask = cand_ten ? '1 : MASK7;
        c_m  = cand & mask;
        a0_m = own_addr0 & mask;
        a1_m = own_addr1 & mask;
        if (range_mode) begin
            hit0 = 1'b0;
            hit1 = (own0_ten == cand_ten) && (a0_m <= c_m) && (c_m <= a1_m);
        end else begin
            hit0 = (own0_ten == cand_ten) && (a0_m == c_m);
            hit1 = (own1_ten == cand_ten) && (a1_m == c_m);
        end
    end

endmodule

// File: rtl/i2cam_hs.sv
module i2cam_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_set,
    input  logic hs_clr,
    output logic hs_active
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hs_active <= 1'b0;
        else if (hs_clr) hs_active <= 1'b0;
        else if (hs_set) hs_active <= 1'b1;
    end

    a_r8_hs_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        hs_clr |=> !hs_active);
    a_r8_hs_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_set && !hs_clr) |=> hs_active);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W = 10,
    parameter int SEVEN_W = 7,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              nack_det,
    input  logic              bit_err,
    input  logic [ADDR_W-1:0] own_addr0,
    input  logic              own0_ten,
    input  logic [ADDR_W-1:0] own_addr1,
    input  logic              own1_ten,
    input  logic              range_mode,
    input  logic              gcall_en,
    input  logic              alert_en,
    input  logic              nack_ignore,
    output logic              match_pulse,
    output logic [2:0]        match_kind,
    output logic              rd_not_wr,
    output logic              hs_active,
    output logic              xfer_active
);
    import i2cam_pkg::*;

    localparam int HI_W = ADDR_W - BYTE_W;

    st_e st, nxt;

    logic               is_gcall, is_alert, is_hs, is_ten;
    logic [SEVEN_W-1:0] addr7;
    logic               h7_0, h7_1, h10_0, h10_1;
    logic [HI_W-1:0]    hdr_hi;
    logic               mem_vld;
    logic [HI_W-1:0]    mem_hi;
    mk_e                mem_kind;

    logic               take;
    mk_e                take_kind;
    logic               take_rd;
    logic               hs_set;
    logic               any_ten;

    i2cam_hdr #(.BYTE_W(BYTE_W), .SEVEN_W(SEVEN_W)) u_hdr (
        .hdr_byte (byte_data),
        .is_gcall (is_gcall),
        .is_alert (is_alert),
        .is_hs    (is_hs),
        .is_ten   (is_ten),
        .addr7    (addr7)
    );

    i2cam_cmp #(.ADDR_W(ADDR_W), .SEVEN_W(SEVEN_W)) u_cmp7 (
        .cand       ({{(ADDR_W-SEVEN_W){1'b0}}, addr7}),
        .cand_ten   (1'b0),
        .own_addr0  (own_addr0),
        .own0_ten   (own0_ten),
        .own_addr1  (own_addr1),
        .own1_ten   (own1_ten),
        .range_mode (range_mode),
        .hit0       (h7_0),
        .hit1       (h7_1)
    );

    i2cam_cmp #(.ADDR_W(ADDR_W), .SEVEN_W(SEVEN_W)) u_cmp10 (
        .cand       ({hdr_hi, byte_data}),
        .cand_ten   (1'b1),
        .own_addr0  (own_addr0),
        .own0_ten   (own0_ten),
        .own_addr1  (own_addr1),
        .own1_ten   (own1_ten),
        .range_mode (range_mode),
        .hit0       (h10_0),
        .hit1       (h10_1)
    );

    i2cam_hs u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_set    (hs_set),
        .hs_clr    (stop_det),
        .hs_active (hs_active)
    );

    assign any_ten = own0_ten || (own1_ten && !range_mode);

    // next state and hit decision
    always_comb begin
        nxt       = st;
        take      = 1'b0;
        take_kind = MK_NONE;
        take_rd   = 1'b0;
        hs_set    = 1'b0;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_HEAD;
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_HEAD: begin
                    if (byte_vld) begin
                        if (is_hs) begin
                            hs_set = 1'b1;
                            nxt    = ST_SKIP;
                        end else if (is_gcall && gcall_en) begin
                            take      = 1'b1;
                            take_kind = MK_GCALL;
                        end else if (is_alert && alert_en) begin
                            take      = 1'b1;
                            take_kind = MK_ALERT;
                            take_rd   = byte_data[0];
                        end else if (is_ten) begin
                            if (byte_data[0] && mem_vld && (mem_hi == byte_data[HI_W:1])) begin
                                take      = 1'b1;
                                take_kind = mem_kind;
                                take_rd   = 1'b1;
                            end else if (!byte_data[0] && any_ten) begin
                                nxt = ST_TENLO;
                            end else begin
                                nxt = ST_SKIP;
                            end
                        end else if (h7_0) begin
                            take      = 1'b1;
                            take_kind = MK_ADDR0;
                            take_rd   = byte_data[0];
                        end else if (h7_1) begin
                            take      = 1'b1;
                            take_kind = MK_ADDR1;
                            take_rd   = byte_data[0];
                        end else begin
                            nxt = ST_SKIP;
                        end
                    end
                end
                ST_TENLO: begin
                    if (byte_vld) begin
                        if (h10_0) begin
                            take      = 1'b1;
                            take_kind = MK_ADDR0;
                        end else if (h10_1) begin
                            take      = 1'b1;
                            take_kind = MK_ADDR1;
                        end else begin
                            nxt = ST_SKIP;
                        end
                    end
                end
                ST_XFER: begin
                    if (bit_err || (nack_det && !nack_ignore)) nxt = ST_SKIP;
                end
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
            if (take) nxt = ST_XFER;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // outputs and address memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_pulse <= 1'b0;
            match_kind  <= MK_NONE;
            rd_not_wr   <= 1'b0;
            xfer_active <= 1'b0;
            hdr_hi      <= '0;
            mem_vld     <= 1'b0;
            mem_hi      <= '0;
            mem_kind    <= MK_NONE;
        end else begin
            match_pulse <= take;
            xfer_active <= (nxt == ST_XFER);
            if (take) begin
                match_kind <= take_kind;
                rd_not_wr  <= take_rd;
            end else if (nxt != ST_XFER) begin
                match_kind <= MK_NONE;
                rd_not_wr  <= 1'b0;
            end
            if (st == ST_HEAD && nxt == ST_TENLO) hdr_hi <= byte_data[HI_W:1];
            if (stop_det) begin
                mem_vld <= 1'b0;
            end else if (take && st == ST_TENLO) begin
                mem_vld  <= 1'b1;
                mem_hi   <= hdr_hi;
                mem_kind <= take_kind;
            end
        end
    end

    a_r1_pulse_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> xfer_active);
    a_r1_rise_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> match_pulse);
    a_r13_kind_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |-> (match_kind == 3'd0));
    a_r11_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!xfer_active && !match_pulse));
    a_r11_start_ends: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !xfer_active);
    a_r10_biterr_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && bit_err) |=> !xfer_active);
    a_r9_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && nack_det && !nack_ignore) |=> !xfer_active);
    a_r9_nack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && nack_det && nack_ignore && !bit_err && !start_det && !stop_det)
        |=> (xfer_active && $stable(match_kind)));

endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_det = 1'b0, stop_det = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       nack_det = 1'b0, bit_err = 1'b0;
    logic [9:0] own_addr0 = 10'h02A, own_addr1 = 10'h051;
    logic       own0_ten = 1'b0, own1_ten = 1'b0, range_mode = 1'b0;
    logic       gcall_en = 1'b0, alert_en = 1'b0, nack_ignore = 1'b0;
    logic       match_pulse, rd_not_wr, hs_active, xfer_active;
    logic [2:0] match_kind;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    i2c_addr_match i_i2c_addr_match (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .byte_vld(byte_vld), .byte_data(byte_data), .nack_det(nack_det), .bit_err(bit_err),
        .own_addr0(own_addr0), .own0_ten(own0_ten), .own_addr1(own_addr1), .own1_ten(own1_ten),
        .range_mode(range_mode), .gcall_en(gcall_en), .alert_en(alert_en),
        .nack_ignore(nack_ignore), .match_pulse(match_pulse), .match_kind(match_kind),
        .rd_not_wr(rd_not_wr), .hs_active(hs_active), .xfer_active(xfer_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {pulse, kind, rd, active}
    function automatic logic [5:0] obs();
        return {match_pulse, match_kind, rd_not_wr, xfer_active};
    endfunction

    task automatic do_start();
        start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    endtask
    task automatic do_stop();
        stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
    endtask
    task automatic do_byte(input logic [7:0] b);
        byte_vld = 1'b1; byte_data = b; @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic t_reset();
        chk("R13 reset", {26'd0, obs()}, 32'd0);
        chk("R13 reset hs", {31'd0, hs_active}, 32'd0);
    endtask

    task automatic t_seven();
        do_start(); do_byte(8'h55);
        chk("R1 addr0 read", {26'd0, obs()}, {26'd0, 1'b1, 3'd1, 1'b1, 1'b1});
        @(negedge clk);
        chk("R1 pulse one cycle", {26'd0, obs()}, {26'd0, 1'b0, 3'd1, 1'b1, 1'b1});
        do_stop();
        chk("R11 stop ends", {26'd0, obs()}, 32'd0);
        do_start(); do_byte(8'hA2);
        chk("R2 addr1 write", {26'd0, obs()}, {26'd0, 1'b1, 3'd2, 1'b0, 1'b1});
        do_stop();
        own_addr1 = 10'h02A;
        do_start(); do_byte(8'h54);
        chk("R2 addr0 priority", {29'd0, match_kind}, 32'd1);
        do_stop();
        own_addr1 = 10'h051;
    endtask

    task automatic t_miss();
        do_byte(8'h54);
        chk("R12 byte in idle", {26'd0, obs()}, 32'd0);
        do_start(); do_byte(8'h60);
        chk("R12 no match", {26'd0, obs()}, 32'd0);
        do_byte(8'h54);
        chk("R12 byte in skip", {26'd0, obs()}, 32'd0);
        do_stop();
    endtask

    task automatic t_range();
        range_mode = 1'b1; own_addr0 = 10'h020; own_addr1 = 10'h030;
        do_start(); do_byte(8'h40);
        chk("R3 low bound", {26'd0, obs()}, {26'd0, 1'b1, 3'd2, 1'b0, 1'b1});
        do_start(); do_byte(8'h61);
        chk("R3 high bound", {26'd0, obs()}, {26'd0, 1'b1, 3'd2, 1'b1, 1'b1});
        do_start(); do_byte(8'h3E);
        chk("R3 below", {31'd0, xfer_active}, 32'd0);
        do_start(); do_byte(8'h62);
        chk("R3 above", {31'd0, xfer_active}, 32'd0);
        do_stop();
        range_mode = 1'b0; own_addr0 = 10'h02A; own_addr1 = 10'h051;
    endtask

    task automatic t_ten();
        own0_ten = 1'b1; own_addr0 = 10'h2A5;
        do_start(); do_byte(8'hF4);
        chk("R4 no hit on header", {26'd0, obs()}, 32'd0);
        do_byte(8'hA5);
        chk("R4 ten-bit hit", {26'd0, obs()}, {26'd0, 1'b1, 3'd1, 1'b0, 1'b1});
        do_start(); do_byte(8'hF5);
        chk("R5 repeated read", {26'd0, obs()}, {26'd0, 1'b1, 3'd1, 1'b1, 1'b1});
        do_stop(); do_start(); do_byte(8'hF5);
        chk("R5 read after stop", {31'd0, xfer_active}, 32'd0);
        do_start(); do_byte(8'hF4); do_byte(8'hA4);
        chk("R4 wrong low byte", {31'd0, xfer_active}, 32'd0);
        do_stop();
        own0_ten = 1'b0; own_addr0 = 10'h02A;
    endtask

    task automatic t_gcall();
        gcall_en = 1'b1;
        do_start(); do_byte(8'h00);
        chk("R6 general call", {26'd0, obs()}, {26'd0, 1'b1, 3'd3, 1'b0, 1'b1});
        gcall_en = 1'b0;
        do_start(); do_byte(8'h00);
        chk("R6 disabled", {31'd0, xfer_active}, 32'd0);
        do_stop();
    endtask

    task automatic t_alert();
        alert_en = 1'b1;
        do_start(); do_byte(8'h19);
        chk("R7 alert", {26'd0, obs()}, {26'd0, 1'b1, 3'd4, 1'b1, 1'b1});
        alert_en = 1'b0;
        do_start(); do_byte(8'h19);
        chk("R7 disabled", {31'd0, xfer_active}, 32'd0);
        do_stop();
    endtask

    task automatic t_hs();
        do_start(); do_byte(8'h0B);
        chk("R8 hs set", {25'd0, hs_active, obs()}, {25'd0, 1'b1, 6'd0});
        do_start(); do_byte(8'h54);
        chk("R8 hs kept on match", {25'd0, hs_active, match_kind}, {25'd0, 1'b1, 3'd1});
        do_stop();
        chk("R8 hs cleared", {31'd0, hs_active}, 32'd0);
    endtask

    task automatic t_nack();
        do_start(); do_byte(8'h54);
        nack_det = 1'b1; @(negedge clk); nack_det = 1'b0;
        chk("R9 nack ends", {26'd0, obs()}, 32'd0);
        nack_ignore = 1'b1;
        do_start(); do_byte(8'h54);
        nack_det = 1'b1; @(negedge clk); nack_det = 1'b0;
        chk("R9 nack ignored", {26'd0, obs()}, {26'd0, 1'b0, 3'd1, 1'b0, 1'b1});
        nack_ignore = 1'b0;
        do_stop();
    endtask

    task automatic t_biterr();
        do_start(); do_byte(8'hA3);
        bit_err = 1'b1; @(negedge clk); bit_err = 1'b0;
        chk("R10 bit error ends", {26'd0, obs()}, 32'd0);
        do_byte(8'h54);
        chk("R12 after bit error", {31'd0, xfer_active}, 32'd0);
        do_stop();
    endtask

    task automatic t_restart();
        do_start(); do_byte(8'h54);
        do_start();
        chk("R11 start ends", {26'd0, obs()}, 32'd0);
        do_byte(8'hA3);
        chk("R11 fresh address", {26'd0, obs()}, {26'd0, 1'b1, 3'd2, 1'b1, 1'b1});
        do_stop();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_seven();
        t_miss();
        t_range();
        t_ten();
        t_gcall();
        t_alert();
        t_hs();
        t_nack();
        t_biterr();
        t_restart();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule